// File: doc/BRIEF.md
# Trigger Interface Register File

This block is the software-visible register set of a trigger interface that sits on a simple synchronous 16-bit bus. Five word locations are decoded below a base address. A control/status word selects the trigger source (external inputs or an upstream trigger supervisor) and enables triggering, interrupts and test mode. The other locations are an interrupt vector, the captured trigger data, an eight-bit general output port and a six-bit input port. The trigger controller and the interrupter are separate blocks. This block drives their configuration levels and three one-clock command strobes: a soft reset, an acknowledge of the current trigger, and a test interrupt request.

Software reads status by addressing a location with `rd_en` high. The read word is built from live state in that cycle and registered, so it appears on `rd_data` from the next cycle on. Unused fields return fixed padding, and the padding differs between locations. A bus access counts only when the upper address bits equal `cfg_base`. The low four address bits select the location.

Top module: `trig_iface_regs`

## Requirements
- R1: Writing the control word (offset 0) stores bits 0..3 as external-mode select, trigger enable, interrupt enable and test enable, in that bit order. These bits drive `mode_ext`, `trig_en`, `irq_en` and `test_en`. They read back at bits 0..3 of offset 0, and bits 4..7 of that word read 0.
- R2: A control write with bit 7 set raises `reset_pulse` for exactly one clock.
- R3: That same write clears the four control bits, the vector register and the output port, whatever the other written bits are.
- R4: Reading offset 0 returns `irq_level` in bits 8..10, `irq_pending` in bit 14 and `trig_valid` in bit 15, with bits 11..13 reading 0. These values are the input levels present in the read cycle.
- R5: Offset 2 holds an 8-bit read/write vector that drives `vector`. Its bits 8..15 read as 1.
- R6: Reading offset 4 returns `trig_data` in bits 0..5, 0 in bit 6, `mode_ext` in bit 7, 0 in bits 8 and 15, and 1 in bits 9..14.
- R7: A write to offset 4 with bit 15 set raises `ack_pulse` for exactly one clock, in either mode.
- R8: A write to offset 4 with bit 8 set raises `test_irq_pulse` for one clock only when test enable and interrupt enable are both set. Otherwise the bit has no effect.
- R9: Offset 6 holds an 8-bit read/write port that drives `out_port`. Its bits 8..15 read as 1.
- R10: Reading offset 8 in supervisor mode returns `ext_in` as sampled in the read cycle in bits 0..5, 0 in bit 6 and 1 in bits 7..15. In external mode the read returns all ones.
- R11: Reads of any other offset, odd offsets included, return all ones. Accesses whose upper address bits differ from `cfg_base` change no register and leave `rd_data` unchanged.
- R12: After reset, every output is 0. `rd_data` changes at the clock edge that samples a read. Strobes rise at the clock edge that samples the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | 12 | Base address compared with bus_addr[15:4] |
| bus_addr | input | 16 | Bus byte address |
| wr_en | input | 1 | Write request this cycle |
| rd_en | input | 1 | Read request this cycle |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| irq_level | input | 3 | Configured interrupt level |
| irq_pending | input | 1 | Interrupter is awaiting acknowledge |
| trig_valid | input | 1 | Trigger controller holds valid data |
| trig_data | input | 6 | Captured trigger data |
| ext_in | input | 6 | Live external trigger and data level inputs |
| mode_ext | output | 1 | External trigger mode selected |
| trig_en | output | 1 | Trigger enable |
| irq_en | output | 1 | Interrupt enable |
| test_en | output | 1 | Test mode enable |
| reset_pulse | output | 1 | One-clock soft reset strobe |
| ack_pulse | output | 1 | One-clock trigger acknowledge strobe |
| test_irq_pulse | output | 1 | One-clock test interrupt request |
| vector | output | 8 | Interrupt vector |
| out_port | output | 8 | General purpose outputs |

## Verification
The hardest condition to reach is the test-interrupt write arriving with only one of its two qualifying enables set. The stimulus walks all four combinations of test and interrupt enable through real control writes, issues the offset 4 strobe write after each one, and checks the strobe against the AND of the two. The soft reset is also driven from a state in which every clearable register holds a distinct non-zero value, so that any register the clear misses stands out. The input port is swept over all 64 input patterns in both modes.

// File: rtl/trig_regs_pkg.sv
package trig_regs_pkg;
  localparam int NUM_REGS = 5;
  localparam int OFFS_W   = 4;

  // index of each location in the one-hot select vector
  localparam int REG_CSR = 0;
  localparam int REG_VEC = 1;
  localparam int REG_TDR = 2;
  localparam int REG_OUT = 3;
  localparam int REG_INP = 4;

  // local offsets, same order as the select indices
  localparam logic [OFFS_W-1:0] REG_OFFS [NUM_REGS] = '{4'h0, 4'h2, 4'h4, 4'h6, 4'h8};

  // control word fields
  localparam int CSR_MODE  = 0;
  localparam int CSR_TEN   = 1;
  localparam int CSR_IEN   = 2;
  localparam int CSR_TEST  = 3;
  localparam int CSR_RST   = 7;
  localparam int CSR_LVL   = 8;
  localparam int CSR_PEND  = 14;
  localparam int CSR_VALID = 15;

  // trigger data word fields
  localparam int TDR_MODE = 7;
  localparam int TDR_TIRQ = 8;
  localparam int TDR_ACK  = 15;
  localparam int TDR_ONE_LO = 9;
  localparam int TDR_ONE_HI = 14;

  typedef struct packed {
    logic test_en;
    logic irq_en;
    logic trig_en;
    logic mode_ext;
  } ctrl_t;
endpackage

// File: rtl/trig_reg_decode.sv
module trig_reg_decode
  import trig_regs_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int BASE_W = ADDR_W - OFFS_W
) (
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BASE_W-1:0]   cfg_base,
  output logic                hit,
  output logic [NUM_REGS-1:0] sel
);
  logic base_ok;
  assign base_ok = (bus_addr[ADDR_W-1:OFFS_W] == cfg_base);
  assign hit     = base_ok;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign sel[g] = base_ok && (bus_addr[OFFS_W-1:0] == REG_OFFS[g]);
  end
endmodule

// File: rtl/trig_reg_ctrl.sv
module trig_reg_ctrl
  import trig_regs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int VEC_W  = 8,
  parameter int OUT_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_stb,
  input  logic [NUM_REGS-1:0] sel,
  input  logic [DATA_W-1:0]   wr_data,
  output ctrl_t               ctrl_q,
  output logic [VEC_W-1:0]    vec_q,
  output logic [OUT_W-1:0]    out_q,
  output logic                rst_pls,
  output logic                ack_pls,
  output logic                tirq_pls
);
  logic wr_csr, wr_vec, wr_tdr, wr_out;
  assign wr_csr = wr_stb && sel[REG_CSR];
  assign wr_vec = wr_stb && sel[REG_VEC];
  assign wr_tdr = wr_stb && sel[REG_TDR];
  assign wr_out = wr_stb && sel[REG_OUT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      vec_q    <= '0;
      out_q    <= '0;
      rst_pls  <= 1'b0;
      ack_pls  <= 1'b0;
      tirq_pls <= 1'b0;
    end else begin
      rst_pls  <= 1'b0;
      ack_pls  <= 1'b0;
      tirq_pls <= 1'b0;
      if (wr_csr) begin
        if (wr_data[CSR_RST]) begin
          ctrl_q  <= '0;
          vec_q   <= '0;
          out_q   <= '0;
          rst_pls <= 1'b1;
        end else begin
          ctrl_q.mode_ext <= wr_data[CSR_MODE];
          ctrl_q.trig_en  <= wr_data[CSR_TEN];
          ctrl_q.irq_en   <= wr_data[CSR_IEN];
          ctrl_q.test_en  <= wr_data[CSR_TEST];
        end
      end
      if (wr_vec) vec_q <= wr_data[VEC_W-1:0];
      if (wr_out) out_q <= wr_data[OUT_W-1:0];
      if (wr_tdr) begin
        if (wr_data[TDR_ACK]) ack_pls <= 1'b1;
        if (wr_data[TDR_TIRQ] && ctrl_q.test_en && ctrl_q.irq_en) tirq_pls <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/trig_reg_readmux.sv
module trig_reg_readmux
  import trig_regs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int VEC_W  = 8,
  parameter int OUT_W  = 8,
  parameter int IN_W   = 6,
  parameter int LVL_W  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_stb,
  input  logic [NUM_REGS-1:0] sel,
  input  ctrl_t               ctrl_q,
  input  logic [VEC_W-1:0]    vec_q,
  input  logic [OUT_W-1:0]    out_q,
  input  logic [LVL_W-1:0]    irq_level,
  input  logic                irq_pending,
  input  logic                trig_valid,
  input  logic [IN_W-1:0]     trig_data,
  input  logic [IN_W-1:0]     ext_in,
  output logic [DATA_W-1:0]   rd_data
);
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '1;
    if (sel[REG_CSR]) begin
      rd_next = '0;
      rd_next[CSR_MODE]  = ctrl_q.mode_ext;
      rd_next[CSR_TEN]   = ctrl_q.trig_en;
      rd_next[CSR_IEN]   = ctrl_q.irq_en;
      rd_next[CSR_TEST]  = ctrl_q.test_en;
      rd_next[CSR_LVL +: LVL_W] = irq_level;
      rd_next[CSR_PEND]  = irq_pending;
      rd_next[CSR_VALID] = trig_valid;
    end else if (sel[REG_VEC]) begin
      rd_next[VEC_W-1:0] = vec_q;
    end else if (sel[REG_TDR]) begin
      rd_next = '0;
      rd_next[TDR_ONE_HI:TDR_ONE_LO] = '1;
      rd_next[TDR_MODE] = ctrl_q.mode_ext;
      rd_next[IN_W-1:0] = trig_data;
    end else if (sel[REG_OUT]) begin
      rd_next[OUT_W-1:0] = out_q;
    end else if (sel[REG_INP]) begin
      if (!ctrl_q.mode_ext) begin
        rd_next[IN_W]     = 1'b0;
        rd_next[IN_W-1:0] = ext_in;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_stb) rd_data <= rd_next;
  end
endmodule

// File: rtl/trig_iface_regs.sv
module trig_iface_regs
  import trig_regs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int VEC_W  = 8,
  parameter int OUT_W  = 8,
  parameter int IN_W   = 6,
  parameter int LVL_W  = 3,
  localparam int BASE_W = ADDR_W - OFFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic              irq_pending,
  input  logic              trig_valid,
  input  logic [IN_W-1:0]   trig_data,
  input  logic [IN_W-1:0]   ext_in,
  output logic              mode_ext,
  output logic              trig_en,
  output logic              irq_en,
  output logic              test_en,
  output logic              reset_pulse,
  output logic              ack_pulse,
  output logic              test_irq_pulse,
  output logic [VEC_W-1:0]  vector,
  output logic [OUT_W-1:0]  out_port
);
  logic                hit;
  logic [NUM_REGS-1:0] sel;
  ctrl_t               ctrl_q;

  trig_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_addr (bus_addr),
    .cfg_base (cfg_base),
    .hit      (hit),
    .sel      (sel)
  );

  trig_reg_ctrl #(.DATA_W(DATA_W), .VEC_W(VEC_W), .OUT_W(OUT_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_stb   (wr_en && hit),
    .sel      (sel),
    .wr_data  (wr_data),
    .ctrl_q   (ctrl_q),
    .vec_q    (vector),
    .out_q    (out_port),
    .rst_pls  (reset_pulse),
    .ack_pls  (ack_pulse),
    .tirq_pls (test_irq_pulse)
  );

  trig_reg_readmux #(.DATA_W(DATA_W), .VEC_W(VEC_W), .OUT_W(OUT_W),
                     .IN_W(IN_W), .LVL_W(LVL_W)) u_rd (
    .clk         (clk),
    .rst         (rst),
    .rd_stb      (rd_en && hit),
    .sel         (sel),
    .ctrl_q      (ctrl_q),
    .vec_q       (vector),
    .out_q       (out_port),
    .irq_level   (irq_level),
    .irq_pending (irq_pending),
    .trig_valid  (trig_valid),
    .trig_data   (trig_data),
    .ext_in      (ext_in),
    .rd_data     (rd_data)
  );

  assign mode_ext = ctrl_q.mode_ext;
  assign trig_en  = ctrl_q.trig_en;
  assign irq_en   = ctrl_q.irq_en;
  assign test_en  = ctrl_q.test_en;
endmodule

// File: rtl/trig_iface_regs_chk.sv
module trig_iface_regs_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int VEC_W  = 8,
  parameter int OUT_W  = 8,
  localparam int BASE_W = ADDR_W - 4
) (
  input logic              clk,
  input logic              rst,
  input logic [BASE_W-1:0] cfg_base,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              mode_ext,
  input logic              trig_en,
  input logic              irq_en,
  input logic              test_en,
  input logic              reset_pulse,
  input logic              ack_pulse,
  input logic              test_irq_pulse,
  input logic [VEC_W-1:0]  vector,
  input logic [OUT_W-1:0]  out_port
);
  logic match;
  assign match = (bus_addr[ADDR_W-1:4] == cfg_base);

  a_r2_reset_pulse_single: assert property (@(posedge clk) disable iff (rst)
    reset_pulse |=> !reset_pulse);

  a_r3_reset_clears_state: assert property (@(posedge clk) disable iff (rst)
    reset_pulse |-> (!mode_ext && !trig_en && !irq_en && !test_en &&
                     vector == '0 && out_port == '0));

  a_r7_ack_single: assert property (@(posedge clk) disable iff (rst)
    ack_pulse |=> !ack_pulse);

  a_r8_test_irq_gated: assert property (@(posedge clk) disable iff (rst)
    test_irq_pulse |-> $past(test_en && irq_en));

  a_r11_foreign_write_ignored: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && match) |=> ($stable(vector) && $stable(out_port) &&
                           $stable({mode_ext, trig_en, irq_en, test_en})));

  a_r11_foreign_read_holds: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && match) |=> $stable(rd_data));

  a_r12_strobe_needs_write: assert property (@(posedge clk) disable iff (rst)
    (reset_pulse || ack_pulse || test_irq_pulse) |-> $past(wr_en && match));
endmodule

bind trig_iface_regs trig_iface_regs_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .VEC_W(VEC_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_base(cfg_base), .bus_addr(bus_addr),
  .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .mode_ext(mode_ext),
  .trig_en(trig_en), .irq_en(irq_en), .test_en(test_en),
  .reset_pulse(reset_pulse), .ack_pulse(ack_pulse),
  .test_irq_pulse(test_irq_pulse), .vector(vector), .out_port(out_port)
);

// File: tb/tb_trig_iface_regs.sv
`timescale 1ns/1ps
module tb_trig_iface_regs;
  localparam logic [11:0] BASE = 12'hA5C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] cfg_base = BASE;
  logic [15:0] bus_addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [2:0]  irq_level = '0;
  logic        irq_pending = 1'b0, trig_valid = 1'b0;
  logic [5:0]  trig_data = '0, ext_in = '0;
  logic        mode_ext, trig_en, irq_en, test_en;
  logic        reset_pulse, ack_pulse, test_irq_pulse;
  logic [7:0]  vector, out_port;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  trig_iface_regs dut (
    .clk(clk), .rst(rst), .cfg_base(cfg_base), .bus_addr(bus_addr),
    .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
    .irq_level(irq_level), .irq_pending(irq_pending), .trig_valid(trig_valid),
    .trig_data(trig_data), .ext_in(ext_in), .mode_ext(mode_ext),
    .trig_en(trig_en), .irq_en(irq_en), .test_en(test_en),
    .reset_pulse(reset_pulse), .ack_pulse(ack_pulse),
    .test_irq_pulse(test_irq_pulse), .vector(vector), .out_port(out_port)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] base, input logic [3:0] off, input logic [15:0] d);
    @(negedge clk);
    bus_addr = {base, off}; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] base, input logic [3:0] off);
    @(negedge clk);
    bus_addr = {base, off}; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [15:0] ctl_out();
    return {12'h000, test_en, irq_en, trig_en, mode_ext};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12: reset state
    chk("R12 rd_data reset", rd_data, 16'h0000);
    chk("R12 outputs reset", {vector, out_port}, 16'h0000);
    chk("R12 strobes reset", {13'h0, reset_pulse, ack_pulse, test_irq_pulse}, 16'h0000);
    chk("R12 ctrl reset", ctl_out(), 16'h0000);

    // R1: all control combinations, junk in the other non-reset bits
    for (int v = 0; v < 16; v++) begin
      wr(BASE, 4'h0, {8'hC3, 1'b0, 3'b111, v[3:0]});
      chk("R1 ctrl outputs", ctl_out(), {12'h0, v[3:0]});
      rd(BASE, 4'h0);
      chk("R1 ctrl readback", rd_data, {12'h0, v[3:0]});
    end

    // R4: status fields, live values
    wr(BASE, 4'h0, 16'h0005);
    for (int s = 0; s < 32; s++) begin
      irq_level = s[2:0]; irq_pending = s[3]; trig_valid = s[4];
      rd(BASE, 4'h0);
      chk("R4 status read", rd_data, {s[4], s[3], 3'b000, s[2:0], 8'h05});
    end
    irq_level = '0; irq_pending = 1'b0; trig_valid = 1'b0;

    // R5 / R9: full sweeps of vector and output port
    for (int i = 0; i < 256; i++) begin
      wr(BASE, 4'h2, {8'h3C, i[7:0]});
      chk("R5 vector output", {8'h00, vector}, {8'h00, i[7:0]});
      rd(BASE, 4'h2);
      chk("R5 vector read", rd_data, {8'hFF, i[7:0]});
      wr(BASE, 4'h6, {8'h5A, ~i[7:0]});
      chk("R9 out_port output", {8'h00, out_port}, {8'h00, ~i[7:0]});
      rd(BASE, 4'h6);
      chk("R9 out_port read", rd_data, {8'hFF, ~i[7:0]});
    end

    // R6 / R10: trigger data and input port in both modes
    for (int m = 0; m < 2; m++) begin
      wr(BASE, 4'h0, {15'h0, m[0]});
      for (int d = 0; d < 64; d++) begin
        trig_data = d[5:0];
        ext_in = ~d[5:0];
        rd(BASE, 4'h4);
        chk("R6 trigger data read", rd_data, 16'h7E00 | (16'(m) << 7) | 16'(d));
        rd(BASE, 4'h8);
        chk("R10 input port read", rd_data,
            (m == 1) ? 16'hFFFF : (16'hFF80 | {10'h0, ~d[5:0]}));
      end
    end

    // R7: acknowledge in both modes
    for (int m = 0; m < 2; m++) begin
      wr(BASE, 4'h0, {15'h0, m[0]});
      wr(BASE, 4'h4, 16'h8000);
      chk("R7 ack raised", {15'h0, ack_pulse}, 16'h0001);
      chk("R7 no test irq from ack", {15'h0, test_irq_pulse}, 16'h0000);
      @(negedge clk);
      chk("R7 ack one clock", {15'h0, ack_pulse}, 16'h0000);
    end

    // R8: test interrupt gating over all enable combinations
    for (int c = 0; c < 4; c++) begin
      wr(BASE, 4'h0, {12'h0, c[1], c[0], 2'b00});
      wr(BASE, 4'h4, 16'h0100);
      chk("R8 test irq gating", {15'h0, test_irq_pulse}, {15'h0, (c == 3)});
      chk("R8 no ack from test bit", {15'h0, ack_pulse}, 16'h0000);
      @(negedge clk);
      chk("R8 test irq one clock", {15'h0, test_irq_pulse}, 16'h0000);
    end

    // R2 / R3: soft reset from a fully loaded state
    wr(BASE, 4'h0, 16'h000F);
    wr(BASE, 4'h2, 16'h005A);
    wr(BASE, 4'h6, 16'h00C3);
    wr(BASE, 4'h0, 16'h008F);
    chk("R2 reset pulse raised", {15'h0, reset_pulse}, 16'h0001);
    chk("R3 ctrl cleared", ctl_out(), 16'h0000);
    chk("R3 vector and port cleared", {vector, out_port}, 16'h0000);
    @(negedge clk);
    chk("R2 reset pulse one clock", {15'h0, reset_pulse}, 16'h0000);

    // R11: unmapped offsets
    for (int o = 0; o < 16; o++) begin
      if (o != 0 && o != 2 && o != 4 && o != 6 && o != 8) begin
        rd(BASE, o[3:0]);
        chk("R11 unmapped read", rd_data, 16'hFFFF);
      end
    end

    // R11: foreign base ignored
    wr(BASE, 4'h2, 16'h0011);
    rd(BASE, 4'h2);
    wr(BASE ^ 12'h001, 4'h2, 16'h00EE);
    wr(BASE ^ 12'h800, 4'h0, 16'h008F);
    chk("R11 foreign write no strobe", {15'h0, reset_pulse}, 16'h0000);
    chk("R11 foreign write ignored", {8'h00, vector}, 16'h0011);
    rd(BASE ^ 12'h001, 4'h6);
    chk("R11 foreign read holds", rd_data, 16'hFF11);

    // R12: read data changes only at the sampling edge
    wr(BASE, 4'h6, 16'h0022);
    @(negedge clk);
    bus_addr = {BASE, 4'h6}; rd_en = 1'b1;
    #1;
    chk("R12 rd_data before edge", rd_data, 16'hFF11);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R12 rd_data after edge", rd_data, 16'hFF22);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule